// File: doc/BRIEF.md
# Counter Read Permission Checker

This block keeps the three counter-enable registers of a hart (machine level, supervisor level and hypervisor level) and decides, in the same cycle, whether a read of a user-visible counter is allowed at the current privilege mode. Each counter has one bit position in every enable register. Bit 0 is the cycle counter, bit 1 is the time counter, bit 2 is the retired-instruction counter, and bits 3 to 31 are the general performance counters 3 to 31. Software writes the enable registers through a simple write port and can read them back through the same port.

A read request gives the privilege mode and a 5-bit counter index. The block raises `allow_o` when the chain of enables permits the read. When the read is denied, it reports which kind of fault to take: illegal-instruction or virtual-instruction. It also gates the counter value that is supplied from outside, so a denied read returns zero. The parameters set which counters exist and whether supervisor mode and the hypervisor are present. An enable bit can be written only when its counter exists. The time bit can never be written, because time is a memory-mapped timer and not a counter register.

Top module: `cnt_access_chk`

## Requirements
- R1: After reset, the machine, supervisor and hypervisor enable registers all read back as zero.
- R2: A write with `csr_sel_i` = 0 (machine), 1 (supervisor) or 2 (hypervisor) stores `csr_wdata_i` ANDed with the implemented-counter mask. The value reads back on `csr_rdata_o` from the next cycle on. Bit 1 (time) always reads back as 0. Select value 3 stores nothing and reads back as 0.
- R3: When `csr_we_i` is low, the enable registers keep their values.
- R4: With `priv_i` = 0 (machine), every counter index is allowed, whatever the enable bits hold.
- R5: With `priv_i` = 1 (supervisor), an implemented counter is allowed exactly when its machine enable bit is set. Otherwise the read is denied as illegal (`fault_o` = 0).
- R6: With `priv_i` = 2 (user), the read needs both the machine bit and the supervisor bit. Otherwise it is denied as illegal.
- R7: With `priv_i` = 3 (virtual supervisor), a clear machine bit gives an illegal fault. A set machine bit with a clear hypervisor bit gives a virtual fault (`fault_o` = 1). When both bits are set, the read is allowed.
- R8: With `priv_i` = 4 (virtual user), a clear machine bit gives an illegal fault. A set machine bit with either the hypervisor bit or the supervisor bit clear gives a virtual fault. When all three bits are set, the read is allowed.
- R9: Below machine mode, an index whose counter is not implemented, the time index 1 included, is denied as illegal, whatever was written.
- R10: `cnt_rd_o` equals `cnt_val_i` when the read is allowed and is zero otherwise. `fault_o` is 0 whenever the read is allowed.
- R11: The `priv_i` codes 5 to 7 are denied as illegal for every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Write strobe for the enable registers |
| csr_sel_i | input | 2 | Register select: 0 machine, 1 supervisor, 2 hypervisor |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read-back of the selected enable register |
| priv_i | input | 3 | Current privilege mode code |
| cnt_idx_i | input | 5 | Index of the counter being read |
| cnt_val_i | input | 32 | Counter value supplied from outside |
| allow_o | output | 1 | The read is permitted |
| fault_o | output | 1 | Kind of denial: 0 illegal-instruction, 1 virtual-instruction |
| cnt_rd_o | output | 32 | Gated counter value |

## Verification
After each set of enable patterns is loaded, the bench sweeps all eight privilege codes against all 32 indices. The patterns are: all enables set, each of the three registers cleared while the other two are full, and three interleaved bit patterns. With one register cleared at a time, each mode's dependence on that register shows on its own, which separates the illegal faults of the machine level from the virtual faults of the hypervisor and supervisor levels. The interleaved patterns set different combinations at different indices, so an index that is decoded wrong or a bit that is swapped shows up. Writing all ones and reading back exposes the mask of implemented counters and the time bit that stays zero. Unimplemented indices and unused mode codes are covered by the same sweeps.

// File: rtl/cnt_access_pkg.sv
package cnt_access_pkg;
  localparam int unsigned NCNT = 32;
  localparam int unsigned IDXW = $clog2(NCNT);
  localparam int unsigned TIME_BIT = 1;

  typedef enum logic [2:0] {
    PRIV_M  = 3'd0,
    PRIV_HS = 3'd1,
    PRIV_U  = 3'd2,
    PRIV_VS = 3'd3,
    PRIV_VU = 3'd4
  } priv_e;

  typedef enum logic [1:0] {
    SEL_MACH = 2'd0,
    SEL_SUP  = 2'd1,
    SEL_HYP  = 2'd2
  } en_sel_e;
endpackage

// File: rtl/cnt_en_reg.sv
module cnt_en_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else if (we_i) q_r <= wdata_i & WMASK;
  end

  assign q_o = q_r;

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == ($past(wdata_i) & WMASK)));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
  a_r9_ro_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o & ~WMASK) == '0));
endmodule

// File: rtl/cnt_perm_decide.sv
module cnt_perm_decide
  import cnt_access_pkg::*;
#(
  parameter logic [NCNT-1:0] IMPL = '1,
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_H = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      priv_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [NCNT-1:0] m_en_i,
  input  logic [NCNT-1:0] s_en_i,
  input  logic [NCNT-1:0] h_en_i,
  output logic            allow_o,
  output logic            virt_o
);
  logic impl_b, m_b, s_b, h_b;

  assign impl_b = IMPL[idx_i];
  assign m_b    = m_en_i[idx_i];
  assign s_b    = s_en_i[idx_i];
  assign h_b    = h_en_i[idx_i];

  always_comb begin
    allow_o = 1'b0;
    virt_o  = 1'b0;
    if (priv_i == PRIV_M) begin
      allow_o = 1'b1;
    end else if (impl_b) begin
      unique case (priv_i)
        PRIV_HS: allow_o = m_b;
        PRIV_U:  allow_o = HAS_S ? (m_b & s_b) : m_b;
        PRIV_VS: if (HAS_H && m_b) begin
          allow_o = h_b;
          virt_o  = !h_b;
        end
        PRIV_VU: if (HAS_H && m_b) begin
          allow_o = h_b & s_b;
          virt_o  = !(h_b & s_b);
        end
        default: allow_o = 1'b0;
      endcase
    end
  end

  a_r4_mach_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == PRIV_M) |-> allow_o);
  a_r9_unimpl_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i != PRIV_M && !IMPL[idx_i]) |-> (!allow_o && !virt_o));
  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(allow_o && virt_o));
  a_r7_mach_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i != PRIV_M && !m_en_i[idx_i]) |-> !virt_o);
endmodule

// File: rtl/cnt_access_chk.sv
module cnt_access_chk
  import cnt_access_pkg::*;
#(
  parameter logic [31:0] IMPL_MASK = 32'h0000_00FF,
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_H = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        csr_we_i,
  input  logic [1:0]  csr_sel_i,
  input  logic [31:0] csr_wdata_i,
  output logic [31:0] csr_rdata_o,
  input  logic [2:0]  priv_i,
  input  logic [4:0]  cnt_idx_i,
  input  logic [31:0] cnt_val_i,
  output logic        allow_o,
  output logic        fault_o,
  output logic [31:0] cnt_rd_o
);
  localparam logic [NCNT-1:0] WMASK = IMPL_MASK & ~(32'd1 << TIME_BIT);
  localparam int unsigned NREG = 3;

  logic [NCNT-1:0] en_q [NREG];
  logic            allow, virt;

  for (genvar g = 0; g < NREG; g++) begin : g_en
    localparam bit PRESENT = !((g == SEL_SUP && !HAS_S) || (g == SEL_HYP && !HAS_H));
    localparam logic [NCNT-1:0] MSK = PRESENT ? WMASK : '0;
    cnt_en_reg #(.W(NCNT), .WMASK(MSK)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (csr_we_i && (csr_sel_i == 2'(g))),
      .wdata_i (csr_wdata_i),
      .q_o     (en_q[g])
    );
  end

  always_comb begin
    unique case (csr_sel_i)
      SEL_MACH: csr_rdata_o = en_q[SEL_MACH];
      SEL_SUP:  csr_rdata_o = en_q[SEL_SUP];
      SEL_HYP:  csr_rdata_o = en_q[SEL_HYP];
      default:  csr_rdata_o = '0;
    endcase
  end

  cnt_perm_decide #(.IMPL(WMASK), .HAS_S(HAS_S), .HAS_H(HAS_H)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .priv_i  (priv_i),
    .idx_i   (cnt_idx_i),
    .m_en_i  (en_q[SEL_MACH]),
    .s_en_i  (en_q[SEL_SUP]),
    .h_en_i  (en_q[SEL_HYP]),
    .allow_o (allow),
    .virt_o  (virt)
  );

  assign allow_o  = allow;
  assign fault_o  = virt;
  assign cnt_rd_o = allow ? cnt_val_i : '0;

  a_r10_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_o |-> (cnt_rd_o == '0));
  a_r11_bad_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i > 3'd4) |-> (!allow_o && !fault_o));
  a_r2_time_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_rdata_o[TIME_BIT] == 1'b0);
endmodule

// File: tb/sim_cnt_access_chk.sv
`timescale 1ns/1ps
module sim_cnt_access_chk;
  localparam logic [31:0] IMPL = 32'h0000_00FF;
  localparam logic [31:0] WM = IMPL & ~32'h2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  priv = '0;
  logic [4:0]  idx = '0;
  logic [31:0] cval = '0;
  logic        allow, fault;
  logic [31:0] crd;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cnt_access_chk #(.IMPL_MASK(IMPL), .HAS_S(1'b1), .HAS_H(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_sel_i(sel),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .priv_i(priv),
    .cnt_idx_i(idx), .cnt_val_i(cval), .allow_o(allow), .fault_o(fault),
    .cnt_rd_o(crd));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); we = 1'b1; sel = s; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [31:0] exp, input string req);
    @(negedge clk); sel = s; #1;
    chk(req, rdata, exp);
  endtask

  // Bench model: returns {allow, fault}
  function automatic logic [1:0] model(input int p, input int i,
      input logic [31:0] m, input logic [31:0] s, input logic [31:0] h);
    bit mb = m[i], sb = s[i], hb = h[i];
    if (p == 0) return 2'b10;
    if (!WM[i]) return 2'b00;
    case (p)
      1: return {mb, 1'b0};
      2: return {mb & sb, 1'b0};
      3: return !mb ? 2'b00 : (hb ? 2'b10 : 2'b01);
      4: return !mb ? 2'b00 : ((hb & sb) ? 2'b10 : 2'b01);
      default: return 2'b00;
    endcase
  endfunction

  task automatic sweep(input logic [31:0] pm, input logic [31:0] ps, input logic [31:0] ph);
    logic [31:0] m = pm & WM, s = ps & WM, h = ph & WM;
    wr(2'd0, pm); wr(2'd1, ps); wr(2'd2, ph);
    rd_chk(2'd0, m, "R2 mach");
    rd_chk(2'd1, s, "R2 sup");
    rd_chk(2'd2, h, "R2 hyp");
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 32; i++) begin
        logic [1:0] e;
        string tag;
        e = model(p, i, m, s, h);
        case (p)
          0: tag = "R4";
          1: tag = "R5";
          2: tag = "R6";
          3: tag = "R7";
          4: tag = "R8";
          default: tag = "R11";
        endcase
        if (p != 0 && !WM[i]) tag = "R9";
        @(negedge clk);
        priv = 3'(p); idx = 5'(i); cval = 32'hA5C3_0000 ^ (32'(p) << 8) ^ 32'(i);
        #1;
        chk(tag, {31'd0, allow}, {31'd0, e[1]});
        chk(tag, {31'd0, fault}, {31'd0, e[0]});
        chk("R10", crd, e[1] ? cval : 32'd0);
      end
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(2'd0, 32'd0, "R1 mach");
    rd_chk(2'd1, 32'd0, "R1 sup");
    rd_chk(2'd2, 32'd0, "R1 hyp");
    // Empty enables: everything below M denied
    sweep(32'd0, 32'd0, 32'd0);
    sweep('1, '1, '1);
    sweep(32'd0, '1, '1);
    sweep('1, 32'd0, '1);
    sweep('1, '1, 32'd0);
    sweep(32'hAAAA_AAAA, 32'hCCCC_CCCC, 32'hF0F0_F0F0);
    sweep(32'h5555_5555, 32'h3333_3333, 32'h0F0F_0F0F);
    sweep(32'h9696_9696, 32'h6969_6969, 32'hFFFF_00FF);
    // R3: no write, values hold over many cycles and unselected write ignored
    wr(2'd3, '1);
    repeat (5) @(negedge clk);
    rd_chk(2'd0, 32'h9696_9696 & WM, "R3 mach hold");
    rd_chk(2'd1, 32'h6969_6969 & WM, "R3 sup hold");
    rd_chk(2'd2, 32'hFFFF_00FF & WM, "R3 hyp hold");
    rd_chk(2'd3, 32'd0, "R2 sel3");
    // R9: time bit ignored on write
    wr(2'd0, 32'h0000_0002);
    rd_chk(2'd0, 32'd0, "R9 time ro");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule